// File: doc/BRIEF.md
# I2C Register-Pointer Slave Interface

This block is a two-wire serial slave that gives an external bus master read and write access to a small register file through a stored pointer. A system clock oversamples SCL and SDA. The block detects START, repeated START and STOP conditions and matches a 7-bit device address. It shifts bytes in and out, and it pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

In a write, the first byte after the address loads the pointer. Each byte that follows is written to the register the pointer selects, and the pointer then advances. A read sends data starting at the pointer and advances the pointer after every byte. The pointer keeps its value across transactions. A master can therefore load the pointer with a short write and then fetch data, either after a STOP or after a repeated START. A timeout pulse from outside forces the bus side back to idle. The register contents and any read-only handling belong to the attached register file.

Top module: `i2cp_slave`

## Requirements
- R1: The device address, MSB first, is 1,0,0,1,1 followed by `addr_strap[1]` and `addr_strap[0]`. A frame with any other address gets no acknowledge: SDA is not pulled at any point until the next START, and the frame causes no register write.
- R2: The eighth bit after START selects the direction. 0 makes the following bytes a write and 1 makes the slave transmit data.
- R3: After the address byte, the command byte and each write-data byte, the slave holds SDA low through the high phase of the ninth SCL clock.
- R4: The first byte after a write address is stored as the pointer. If STOP follows it, the pointer changes and no register is written.
- R5: Each further write byte is presented on `reg_wdata` with `reg_we` high for one clock at `reg_addr` equal to the pointer, and the pointer then advances.
- R6: A read transmits bytes MSB first, starting at the stored pointer, and advances the pointer after each byte. A repeated START after a pointer-setting write keeps the pointer.
- R7: The pointer advances from any value at or above LAST_REG (default 0x27) to 0, and otherwise by one.
- R8: When the master answers a read byte with NACK (SDA high in the ninth clock), the slave releases SDA and drives nothing until a new START.
- R9: A `timeout_rst` pulse returns the slave to idle and releases SDA. This holds even in the cycle where an acknowledge would start. The pointer keeps its value.
- R10: The SDA pull changes only while SCL is low, after an SCL falling edge has been detected.
- R11: After reset, SDA is released, the pointer is 0 and no register write has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| addr_strap | input | 2 | Two low bits of the device address |
| timeout_rst | input | 1 | Pulse that forces the bus side to idle |
| reg_addr | output | 8 | Register file address (current pointer) |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-clock register write strobe |
| reg_rdata | input | 8 | Register file read data at `reg_addr` |

## Verification
A timeout pulse and the SCL falling edge that closes a received byte can reach the controller in the same clock. The falling edge would start an acknowledge and the pulse would cancel the frame. The bench provokes this by raising `timeout_rst` for several clocks across the falling edge of the eighth command bit. That window covers the detected edge whatever the synchronizer delay. Timeout must win: SDA stays released through the ninth clock and during the remaining bits. A later read must then start from the pointer that was stored before the interrupted frame.

// File: rtl/i2cp_pkg.sv
// Package: shared state encoding and address constants for the register-pointer slave.
// Assumes a 7-bit address of which the two low bits are strapped at the top level.
package i2cp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } i2cp_state_t;

    localparam logic [4:0] DEV_ADDR_HI = 5'b10011;

endpackage

// File: rtl/i2cp_line_sync.sv
// Module: i2cp_line_sync
// Brings one asynchronous bus line into the clock domain and flags its edges.
// Assumes the idle level of the line is high, so all stages reset to 1.
module i2cp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES:0] pipe;

    // Shift the raw line through the synchronizer stages plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], line_i};
    end

    assign level_o = pipe[LAST];
    assign rise_o  = pipe[LAST] & ~pipe[STAGES];
    assign fall_o  = ~pipe[LAST] & pipe[STAGES];

endmodule

// File: rtl/i2cp_ptr.sv
// Module: i2cp_ptr
// Holds the register pointer: loaded by a command byte, advanced after each data byte.
// Assumes load and advance are never requested in the same cycle; load wins if they are.
module i2cp_ptr #(
    parameter int              W        = 8,
    parameter logic [W-1:0]    LAST_REG = 8'h27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] ptr_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Pointer register with wrap to zero past the last implemented register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_o <= '0;
        else if (load_i) ptr_o <= load_val_i;
        else if (inc_i)  ptr_o <= (ptr_o >= LAST_REG) ? '0 : ptr_o + ONE;
    end

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_i) && !$past(load_i) && $past(ptr_o) >= LAST_REG) |-> (ptr_o == '0));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_i) && !$past(load_i) && $past(ptr_o) < LAST_REG) |-> (ptr_o == $past(ptr_o) + ONE));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(inc_i) && !$past(load_i)) |-> $stable(ptr_o));

endmodule

// File: rtl/i2cp_slave.sv
// Module: i2cp_slave
// Two-wire bus slave with a persistent register pointer. Oversamples SCL/SDA,
// decodes START/STOP, matches the device address, receives command and data
// bytes, transmits register data and drives SDA through an open-drain enable.
// Assumes the system clock is several times faster than SCL and that the
// register file answers reg_rdata combinationally from reg_addr.
module i2cp_slave
    import i2cp_pkg::*;
#(
    parameter int           SYNC_STAGES = 2,
    parameter int           PTR_W       = 8,
    parameter logic [7:0]   LAST_REG    = 8'h27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic [1:0]       addr_strap,
    input  logic             timeout_rst,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata
);

    localparam int          SCL_IDX  = 0;
    localparam int          SDA_IDX  = 1;
    localparam logic [3:0]  BYTE_LEN = 4'd8;

    logic [1:0] raw_lines, lvl, rise, fall;
    assign raw_lines = {sda_i, scl_i};

    // One synchronizer and edge detector per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2cp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .level_o(lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    logic scl_rise, scl_fall, sda_lvl, start_evt, stop_evt, quiet;
    assign scl_rise  = rise[SCL_IDX];
    assign scl_fall  = fall[SCL_IDX];
    assign sda_lvl   = lvl[SDA_IDX];
    assign start_evt = fall[SDA_IDX] & lvl[SCL_IDX];
    assign stop_evt  = rise[SDA_IDX] & lvl[SCL_IDX];
    assign quiet     = !timeout_rst && !start_evt && !stop_evt;

    i2cp_state_t state;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        rw_q, pull_q, mack_q;

    logic             addr_hit, byte_done, ptr_load, ptr_inc, load_rd;
    logic [PTR_W-1:0] ptr;

    assign addr_hit  = (shreg[7:1] == {DEV_ADDR_HI, addr_strap});
    assign byte_done = scl_fall && (bitcnt == BYTE_LEN) && quiet;
    assign reg_we    = (state == ST_WDATA) && byte_done;
    assign ptr_load  = (state == ST_CMD) && byte_done;
    assign load_rd   = quiet && scl_fall &&
                       (((state == ST_ADDR_ACK) && rw_q) || ((state == ST_RACK) && mack_q));
    assign ptr_inc   = reg_we || load_rd;

    i2cp_ptr #(.W(PTR_W), .LAST_REG(LAST_REG[PTR_W-1:0])) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ptr_load),
        .load_val_i(shreg[PTR_W-1:0]),
        .inc_i     (ptr_inc),
        .ptr_o     (ptr)
    );

    assign reg_addr   = ptr;
    assign reg_wdata  = shreg;
    assign sda_pull_o = pull_q;

    // Frame controller: bit counting, shifting, acknowledge and read-data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            pull_q <= 1'b0;
            mack_q <= 1'b0;
        end else if (timeout_rst) begin
            state  <= ST_IDLE;
            pull_q <= 1'b0;
        end else if (start_evt) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            pull_q <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            pull_q <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && bitcnt < BYTE_LEN) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                rw_q   <= shreg[0];
                                pull_q <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end else begin
                            pull_q <= 1'b1;
                            state  <= (state == ST_CMD) ? ST_CMD_ACK : ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (load_rd) begin
                            shreg  <= reg_rdata;
                            pull_q <= ~reg_rdata[7];
                            bitcnt <= 4'd1;
                            state  <= ST_RDATA;
                        end else begin
                            pull_q <= 1'b0;
                            state  <= ST_WDATA;
                            if (state == ST_ADDR_ACK) state <= ST_CMD;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == BYTE_LEN) begin
                            pull_q <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_RACK;
                        end else begin
                            pull_q <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (load_rd) begin
                            shreg  <= reg_rdata;
                            pull_q <= ~reg_rdata[7];
                            bitcnt <= 4'd1;
                            state  <= ST_RDATA;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_rst |=> (!sda_pull_o && state == ST_IDLE));

    // R10
    pull_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> $past(scl_fall || timeout_rst || start_evt || stop_evt));

    // R1
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR) && byte_done && !addr_hit) |=> (!sda_pull_o && state == ST_IDLE));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RACK) && scl_fall && !mack_q && quiet) |=> (!sda_pull_o && state == ST_IDLE));

    // R5
    write_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (state == ST_WDATA_ACK && sda_pull_o));

endmodule

// File: tb/i2cp_slave_test.sv
// Bench: bit-level bus master, register file model and expected-value model.
module i2cp_slave_test;

    localparam int         Q    = 10;
    localparam logic [7:0] LAST = 8'h27;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, timeout_rst = 1'b0;
    logic       sda_pull, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire        sda_bus = sda_m & ~sda_pull;

    logic [7:0] regs    [0:255];
    logic [7:0] exp_mem [0:255];
    logic [7:0] exp_ptr;
    int checks = 0, fails = 0, wr_cnt = 0, pull_cnt = 0, r10_viol = 0;
    bit done = 0;
    logic prev_pull = 1'b0;

    i2cp_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .addr_strap(STRAP), .timeout_rst(timeout_rst),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    // Register file model and line monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (sda_pull) pull_cnt <= pull_cnt + 1;
        if (rst_n && sda_pull !== prev_pull && scl_m) r10_viol <= r10_viol + 1; // R10
        prev_pull <= sda_pull;
    end

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p >= LAST) ? 8'h00 : p + 8'h01;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic clock_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q / 2);
        acked = (sda_bus == 1'b0);
        wq(Q / 2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q / 2);
            b[i] = sda_bus;
            wq(Q / 2); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
        wq(1); sda_m = 1'b1;
    endtask

    task automatic m_write(input logic [7:0] cmd, input int n, input bit do_stop);
        bit ak;
        logic [7:0] d;
        bus_start();
        send_byte({5'b10011, STRAP, 1'b0}, ak);
        check(ak, "R1 address ack", ak, 1);
        send_byte(cmd, ak);
        check(ak, "R3 command ack", ak, 1);
        exp_ptr = cmd;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ak);
            check(ak, "R3 data ack", ak, 1);
            exp_mem[exp_ptr] = d;
            exp_ptr = nxt(exp_ptr);
        end
        if (do_stop) bus_stop();
    endtask

    task automatic m_read(input int n, input bit rstart, input string req);
        bit ak;
        logic [7:0] d;
        if (rstart) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(2);
        end else begin
            bus_start();
        end
        send_byte({5'b10011, STRAP, 1'b1}, ak);
        check(ak, "R2 read address ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            check(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
            exp_ptr = nxt(exp_ptr);
        end
        bus_stop();
    endtask

    task automatic verify_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i <= int'(LAST); i++)
            if (regs[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        check(bad == 0, req, bad, 0);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ak;
        int w0;
        void'($urandom(32'd7302));
        for (int i = 0; i < 256; i++) begin
            regs[i]    = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        exp_ptr = 8'h00;
        wq(5); rst_n = 1'b1; wq(3);

        // R11: released line, no writes, pointer at zero (first read comes from register 0)
        check(sda_pull == 1'b0, "R11 pull after reset", sda_pull, 0);
        check(wr_cnt == 0, "R11 no write after reset", wr_cnt, 0);
        m_read(1, 0, "R11 first read from register 0");

        // R1: strap mismatch and upper-bit mismatch are ignored
        w0 = wr_cnt;
        bus_start(); pull_cnt = 0;
        send_byte({5'b10011, STRAP ^ 2'b01, 1'b0}, ak);
        check(!ak, "R1 strap mismatch no ack", ak, 0);
        send_byte(8'h05, ak);
        send_byte(8'hEE, ak);
        check(pull_cnt == 0, "R1 line untouched on mismatch", pull_cnt, 0);
        bus_stop();
        bus_start(); pull_cnt = 0;
        send_byte({5'b10100, STRAP, 1'b0}, ak);
        check(!ak && pull_cnt == 0, "R1 upper-bit mismatch", pull_cnt, 0);
        bus_stop();
        check(wr_cnt == w0, "R1 no write on mismatch", wr_cnt, w0);

        // R5: burst write then memory compare
        m_write(8'h05, 3, 1);
        verify_mem("R5 burst write contents");
        check(exp_ptr == 8'h08, "R5 pointer after burst", exp_ptr, 8);

        // R4: pointer-only write then read after STOP
        w0 = wr_cnt;
        m_write(8'h10, 0, 1);
        check(wr_cnt == w0, "R4 no write for command only", wr_cnt, w0);
        m_read(2, 0, "R4 read from stored pointer");

        // R6 and R7: repeated START read across the wrap point
        m_write(8'h26, 0, 0);
        m_read(3, 1, "R6 R7 repeated start read with wrap");

        // R7: write across the wrap point
        m_write(LAST, 2, 1);
        verify_mem("R7 write wraps to register 0");

        // Random mix of writes, pointer loads with repeated START, and plain reads
        for (int it = 0; it < 24; it++) begin
            int op = int'($urandom % 3);
            if (op == 0) begin
                m_write(8'($urandom % (int'(LAST) + 1)), 1 + int'($urandom % 4), 1);
            end else if (op == 1) begin
                m_write(8'($urandom % (int'(LAST) + 1)), 0, 0);
                m_read(1 + int'($urandom % 4), 1, "R6 random repeated start read");
            end else begin
                m_read(1 + int'($urandom % 3), 0, "R6 random read from persistent pointer");
            end
        end
        verify_mem("R5 random write contents");

        // R8: after NACK the slave stays off the line while SCL keeps toggling
        begin
            logic [7:0] d;
            bus_start();
            send_byte({5'b10011, STRAP, 1'b1}, ak);
            recv_byte(1'b0, d);
            check(d == exp_mem[exp_ptr], "R8 byte before nack", d, exp_mem[exp_ptr]);
            exp_ptr = nxt(exp_ptr);
            wq(4); pull_cnt = 0;
            for (int i = 0; i < 9; i++) clock_bit(1'b0);
            check(pull_cnt == 0, "R8 released after nack", pull_cnt, 0);
            bus_stop();
        end

        // R9: timeout held across the falling edge that would start the command ack
        w0 = wr_cnt;
        bus_start();
        send_byte({5'b10011, STRAP, 1'b0}, ak);
        for (int i = 0; i < 7; i++) clock_bit(1'b1);
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
        timeout_rst = 1'b1; scl_m = 1'b0; wq(6); timeout_rst = 1'b0;
        check(sda_pull == 1'b0, "R9 released at timeout", sda_pull, 0);
        pull_cnt = 0;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
        for (int i = 0; i < 8; i++) clock_bit(1'b0);
        check(pull_cnt == 0, "R9 no ack after timeout", pull_cnt, 0);
        bus_stop();
        check(wr_cnt == w0, "R9 no write after timeout", wr_cnt, w0);
        m_read(1, 0, "R9 pointer kept through timeout");

        wq(5);
        check(r10_viol == 0, "R10 pull changed while SCL high", r10_viol, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule